// File: doc/BRIEF.md
# Mode-configurable clock divider chain

This block is the digital divider and mode logic that surrounds a frequency synthesizer. It runs on the oscillator-side clock `clk`. In external clock mode that clock is the external input itself. While reset is held, the block decodes two strap pins into one of three clock topologies and keeps that choice until the next reset. It holds one register of divider fields: a 3-bit W, a 1-bit X and a 6-bit Y. The latched mode decides which of these fields set the feedback divider and which set the output divider. The feedback divider is compared against the reference. The output divider forms the system clock.

Both divided clocks leave the block as single-cycle enable pulses, `fb_tick` and `sys_tick`, with one pulse per divided period. A clock-gating cell elsewhere turns each pulse train into a clock. Each divider loads a new ratio only at its own terminal count, so the period that is running when a field is written always completes at full length.

In the two synthesizer modes, a lock detector counts rising edges of the reference and feedback pulses over windows of 16 reference edges. It raises `locked` once two windows in a row agree. The lock state machine has four states:
- LK_OFF: external mode, no lock.
- LK_HUNT: no good window yet.
- LK_ONE: one good window.
- LK_LOCKED: locked.

Its transitions are:
- HUNT to ONE on a good window.
- ONE to LOCKED on a good window.
- ONE or LOCKED to HUNT on a bad window.
- Any PLL state to HUNT on a feedback-field write.
- HUNT to OFF when the latched mode is external.

Top module: `clkdiv_chain`

## Requirements
- R1: The mode is sampled only while `rst_n` is low. `strap_modck`=0 selects external mode. `strap_modck`=1 with `strap_fastref`=1 selects fast-reference mode. `strap_modck`=1 with `strap_fastref`=0 selects slow-reference mode. Strap changes after reset has been released have no effect.
- R2: The reset field values depend on the mode. In fast and external modes, W=0, X=0 and Y=0, which gives a feedback period of 1 and a system period of 1. In slow mode, W=0, X=0 and Y=3, which gives a feedback period of 64 and a system period of 1.
- R3: In slow mode, the feedback period in `clk` cycles is (Y+1)·2^(W[0]+4). Its range is 16 to 2048.
- R4: In slow mode, the system period is 2^X. Writing X leaves the feedback period unchanged and does not clear `locked`.
- R5: In fast mode, the feedback period is W+1, a range of 1 to 8.
- R6: In fast and external modes, the system period is (Y[2:0]+1)·2^X.
- R7: In external mode, `fb_tick` never pulses and `locked` stays 0, whatever is written.
- R8: In a PLL mode, `locked` becomes 1 after two consecutive windows of 16 reference rising edges. In each of these windows the feedback pulse count must be 15, 16 or 17. A window outside that range clears `locked`. `locked` is 0 after reset.
- R9: A write to a feedback field clears `locked` at the next clock edge. The feedback fields are W or Y in slow mode and W in fast mode. A Y or X write in fast mode, or an X write in slow mode, leaves `locked` unchanged.
- R10: A new ratio takes effect at the divider's terminal count. The period during which a write lands completes with the old length, and the next period uses the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side or external clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| ref_in | input | 1 | Reference clock, synchronized internally |
| strap_modck | input | 1 | Mode strap; 0 selects external clock mode |
| strap_fastref | input | 1 | Reference-speed strap; 1 selects fast reference |
| w_wr | input | 1 | Write strobe for W |
| x_wr | input | 1 | Write strobe for X |
| y_wr | input | 1 | Write strobe for Y |
| w_data | input | 3 | W value to write |
| x_data | input | 1 | X value to write |
| y_data | input | 6 | Y value to write |
| fb_tick | output | 1 | One pulse per feedback-divider period |
| sys_tick | output | 1 | One pulse per system-clock period |
| locked | output | 1 | Lock flag |

## Verification
The bench builds the block with its default parameters: a 3-bit W, a 6-bit Y, a 16-edge lock window and a two-stage reference synchronizer. With these values the slow-mode ceiling of 2048 can be measured directly as a feedback period. The 16-edge window keeps lock acquisition within a few thousand cycles, even at the slow-mode reset ratio of 64. The bench plays the part of the oscillator loop. It drives a reference whose period equals the programmed feedback ratio, so that lock forms, or a mismatched period, so that it does not. It then checks which field writes break the lock and which leave it alone.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        CM_EXT,
        CM_SLOW,
        CM_FAST
    } clk_mode_e;

    typedef enum logic [1:0] {
        LK_OFF,
        LK_HUNT,
        LK_ONE,
        LK_LOCKED
    } lock_state_e;

endpackage

// File: rtl/clkdiv_mode_regs.sv
module clkdiv_mode_regs
    import clkdiv_pkg::*;
#(
    parameter int W_BITS          = 3,
    parameter int Y_BITS          = 6,
    parameter int OUT_Y_BITS      = 3,
    parameter int SLOW_BASE_SHIFT = 4,
    parameter int SLOW_Y_RESET    = 3,
    parameter int RW              = Y_BITS + SLOW_BASE_SHIFT + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_modck,
    input  logic              strap_fastref,
    input  logic              w_wr,
    input  logic              x_wr,
    input  logic              y_wr,
    input  logic [W_BITS-1:0] w_data,
    input  logic              x_data,
    input  logic [Y_BITS-1:0] y_data,
    output clk_mode_e         mode,
    output logic [RW-1:0]     fb_ratio,
    output logic [RW-1:0]     sys_ratio,
    output logic              fb_write
);

    clk_mode_e         strap_mode;
    logic [W_BITS-1:0] w_q;
    logic              x_q;
    logic [Y_BITS-1:0] y_q;

    always_comb begin
        if (!strap_modck)      strap_mode = CM_EXT;
        else if (strap_fastref) strap_mode = CM_FAST;
        else                   strap_mode = CM_SLOW;
    end

    // mode is loaded only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= strap_mode;
            w_q  <= '0;
            x_q  <= 1'b0;
            y_q  <= (strap_mode == CM_SLOW) ? Y_BITS'(SLOW_Y_RESET) : '0;
        end else begin
            if (w_wr) w_q <= w_data;
            if (x_wr) x_q <= x_data;
            if (y_wr) y_q <= y_data;
        end
    end

    always_comb begin
        unique case (mode)
            CM_SLOW: begin
                fb_ratio  = (RW'(y_q) + RW'(1)) << (SLOW_BASE_SHIFT + int'(w_q[0]));
                sys_ratio = RW'(1) << x_q;
                fb_write  = w_wr | y_wr;
            end
            CM_FAST: begin
                fb_ratio  = RW'(w_q) + RW'(1);
                sys_ratio = (RW'(y_q[OUT_Y_BITS-1:0]) + RW'(1)) << x_q;
                fb_write  = w_wr;
            end
            default: begin
                fb_ratio  = RW'(1);
                sys_ratio = (RW'(y_q[OUT_Y_BITS-1:0]) + RW'(1)) << x_q;
                fb_write  = 1'b0;
            end
        endcase
    end

    // R1: latched mode never moves once reset is released
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

endmodule

// File: rtl/clkdiv_divider.sv
module clkdiv_divider #(
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [RW-1:0] ratio,
    output logic          tick
);

    logic [RW-1:0] cnt;
    logic [RW-1:0] active;

    assign tick = en && (cnt == active - RW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            active <= RW'(1);
        end else if (tick) begin
            cnt    <= '0;
            active <= (ratio == '0) ? RW'(1) : ratio;
        end else begin
            cnt    <= cnt + RW'(1);
        end
    end

    // R10: the phase counter stays inside the period it was loaded with
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < active));

endmodule

// File: rtl/clkdiv_lock_fsm.sv
module clkdiv_lock_fsm
    import clkdiv_pkg::*;
#(
    parameter int WIN_LEN     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_ext,
    input  logic ref_in,
    input  logic fb_tick,
    input  logic fb_write,
    output logic locked
);

    localparam int WIN_W = $clog2(WIN_LEN);

    lock_state_e           state_q, state_d;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                  ref_prev;
    logic                  ref_edge;
    logic [WIN_W-1:0]      ref_cnt;
    logic [CNT_W-1:0]      fb_cnt;
    logic [CNT_W-1:0]      fb_sum;
    logic                  win_end;
    logic                  win_good;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= '0;
            ref_prev <= 1'b0;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], ref_in};
            ref_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ref_edge = sync_q[SYNC_STAGES-1] & ~ref_prev;
    assign win_end  = ref_edge && (ref_cnt == WIN_W'(WIN_LEN - 1));
    assign fb_sum   = (fb_cnt == '1) ? fb_cnt : fb_cnt + CNT_W'(fb_tick);
    assign win_good = (fb_sum >= CNT_W'(WIN_LEN - 1)) && (fb_sum <= CNT_W'(WIN_LEN + 1));

    always_ff @(posedge clk) begin
        if (!rst_n || fb_write || is_ext || win_end) begin
            ref_cnt <= '0;
            fb_cnt  <= '0;
        end else begin
            if (ref_edge) ref_cnt <= ref_cnt + WIN_W'(1);
            fb_cnt <= fb_sum;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_HUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OFF:    state_d = LK_OFF;
            LK_HUNT: begin
                if (is_ext)                    state_d = LK_OFF;
                else if (fb_write)             state_d = LK_HUNT;
                else if (win_end && win_good)  state_d = LK_ONE;
            end
            LK_ONE: begin
                if (fb_write)                  state_d = LK_HUNT;
                else if (win_end)              state_d = win_good ? LK_LOCKED : LK_HUNT;
            end
            LK_LOCKED: begin
                if (fb_write)                  state_d = LK_HUNT;
                else if (win_end && !win_good) state_d = LK_HUNT;
            end
            default:                           state_d = LK_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_LOCKED: locked = 1'b1;
            default:   locked = 1'b0;
        endcase
    end

    // R7: never locked while the latched mode is external
    p_no_lock_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext |-> !locked);

    // R9: a feedback-field write drops lock at the next edge
    p_clear_on_fbwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fb_write |=> !locked);

    // R8: lock only rises at the close of a good window
    p_lock_at_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_end && win_good));

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
    import clkdiv_pkg::*;
#(
    parameter int W_BITS          = 3,
    parameter int Y_BITS          = 6,
    parameter int OUT_Y_BITS      = 3,
    parameter int SLOW_BASE_SHIFT = 4,
    parameter int SLOW_Y_RESET    = 3,
    parameter int WIN_LEN         = 16,
    parameter int SYNC_STAGES     = 2,
    parameter int LOCK_CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              strap_modck,
    input  logic              strap_fastref,
    input  logic              w_wr,
    input  logic              x_wr,
    input  logic              y_wr,
    input  logic [W_BITS-1:0] w_data,
    input  logic              x_data,
    input  logic [Y_BITS-1:0] y_data,
    output logic              fb_tick,
    output logic              sys_tick,
    output logic              locked
);

    localparam int RW = Y_BITS + SLOW_BASE_SHIFT + 2;

    clk_mode_e     mode;
    logic [RW-1:0] fb_ratio;
    logic [RW-1:0] sys_ratio;
    logic          fb_write;
    logic          is_ext;

    assign is_ext = (mode == CM_EXT);

    clkdiv_mode_regs #(
        .W_BITS(W_BITS), .Y_BITS(Y_BITS), .OUT_Y_BITS(OUT_Y_BITS),
        .SLOW_BASE_SHIFT(SLOW_BASE_SHIFT), .SLOW_Y_RESET(SLOW_Y_RESET), .RW(RW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .strap_modck(strap_modck), .strap_fastref(strap_fastref),
        .w_wr(w_wr), .x_wr(x_wr), .y_wr(y_wr),
        .w_data(w_data), .x_data(x_data), .y_data(y_data),
        .mode(mode), .fb_ratio(fb_ratio), .sys_ratio(sys_ratio),
        .fb_write(fb_write)
    );

    clkdiv_divider #(.RW(RW)) fb_div_i (
        .clk(clk), .rst_n(rst_n), .en(!is_ext), .ratio(fb_ratio), .tick(fb_tick)
    );

    clkdiv_divider #(.RW(RW)) sys_div_i (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .ratio(sys_ratio), .tick(sys_tick)
    );

    clkdiv_lock_fsm #(
        .WIN_LEN(WIN_LEN), .SYNC_STAGES(SYNC_STAGES), .CNT_W(LOCK_CNT_W)
    ) lock_i (
        .clk(clk), .rst_n(rst_n), .is_ext(is_ext), .ref_in(ref_in),
        .fb_tick(fb_tick), .fb_write(fb_write), .locked(locked)
    );

    // R7: the feedback divider is silent in external mode
    p_no_fb_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext |-> !fb_tick);

endmodule

// File: tb/clkdiv_chain_tb_top.sv
module clkdiv_chain_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       strap_modck = 1'b1;
    logic       strap_fastref = 1'b1;
    logic       w_wr = 1'b0, x_wr = 1'b0, y_wr = 1'b0;
    logic [2:0] w_data = '0;
    logic       x_data = 1'b0;
    logic [5:0] y_data = '0;
    logic       fb_tick, sys_tick, locked;

    int errors = 0;
    int checks = 0;
    int ref_half = 0;
    int ref_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkdiv_chain dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .strap_modck(strap_modck), .strap_fastref(strap_fastref),
        .w_wr(w_wr), .x_wr(x_wr), .y_wr(y_wr),
        .w_data(w_data), .x_data(x_data), .y_data(y_data),
        .fb_tick(fb_tick), .sys_tick(sys_tick), .locked(locked)
    );

    // bench stands in for the oscillator loop: reference period = 2*ref_half
    always @(negedge clk) begin
        if (ref_half != 0) begin
            ref_cnt = ref_cnt + 1;
            if (ref_cnt >= ref_half) begin
                ref_cnt = 0;
                ref_in  = ~ref_in;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic modck, input logic fastref);
        ref_half = 0;
        rst_n = 1'b0;
        strap_modck = modck;
        strap_fastref = fastref;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input bit we, input logic [2:0] w, input bit xe, input logic x,
                      input bit ye, input logic [5:0] y);
        @(negedge clk);
        w_wr = we; w_data = w;
        x_wr = xe; x_data = x;
        y_wr = ye; y_data = y;
        @(negedge clk);
        w_wr = 1'b0; x_wr = 1'b0; y_wr = 1'b0;
    endtask

    // cycles between two consecutive pulses; 0 if none within the limit
    task automatic period(input bit use_fb, output int per);
        int n;
        per = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_fb ? fb_tick : sys_tick) && n < 5000);
        if (n >= 5000) return;
        // skip the first period after a write so the new ratio is loaded
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_fb ? fb_tick : sys_tick) && n < 5000);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_fb ? fb_tick : sys_tick) && n < 5000);
        per = (n >= 5000) ? 0 : n;
    endtask

    task automatic fb_pulses(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (fb_tick) cnt++;
        end
    endtask

    task automatic test_fast();
        int p;
        do_reset(1'b1, 1'b1);
        chk("R8", "locked after reset", int'(locked), 0);
        period(1'b1, p); chk("R2", "fast reset fb period", p, 1);
        period(1'b0, p); chk("R2", "fast reset sys period", p, 1);
        wr(1, 3'd3, 0, 0, 0, 0);
        period(1'b1, p); chk("R5", "fast fb period W=3", p, 4);
        strap_modck = 1'b0;
        period(1'b1, p); chk("R1", "strap change ignored, fb period", p, 4);
        ref_half = 2;
        repeat (3000) @(negedge clk);
        chk("R8", "fast locked on matching ref", int'(locked), 1);
        wr(0, 0, 1, 1'b1, 1, 6'd2);
        chk("R9", "locked kept after Y/X write in fast", int'(locked), 1);
        period(1'b0, p); chk("R6", "fast sys period Y=2 X=1", p, 6);
        @(negedge clk);
        w_wr = 1'b1; w_data = 3'd2;
        @(negedge clk);
        w_wr = 1'b0;
        chk("R9", "locked cleared after W write", int'(locked), 0);
        period(1'b1, p); chk("R5", "fast fb period W=2", p, 3);
        repeat (3000) @(negedge clk);
        chk("R8", "no lock on mismatched ref", int'(locked), 0);
        strap_modck = 1'b1;
    endtask

    task automatic test_tc();
        int p;
        int n;
        do_reset(1'b1, 1'b1);
        wr(0, 0, 0, 0, 1, 6'd3);
        period(1'b0, p); chk("R6", "fast sys period Y=3", p, 4);
        n = 0;
        while (!sys_tick && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
        y_wr = 1'b1; y_data = 6'd7;
        n = 1;
        @(negedge clk);
        y_wr = 1'b0;
        n = 2;
        while (!sys_tick && n < 100) begin @(negedge clk); n++; end
        chk("R10", "period holding the write keeps old length", n, 4);
        n = 0;
        do begin @(negedge clk); n++; end while (!sys_tick && n < 100);
        chk("R10", "next period uses new length", n, 8);
    endtask

    task automatic test_slow();
        int p;
        do_reset(1'b1, 1'b0);
        period(1'b1, p); chk("R2", "slow reset fb period", p, 64);
        period(1'b0, p); chk("R2", "slow reset sys period", p, 1);
        ref_half = 32;
        repeat (4500) @(negedge clk);
        chk("R8", "slow locked on matching ref", int'(locked), 1);
        wr(0, 0, 1, 1'b1, 0, 0);
        period(1'b0, p); chk("R4", "slow sys period X=1", p, 2);
        period(1'b1, p); chk("R4", "slow fb period unchanged by X", p, 64);
        chk("R4", "locked kept after X write", int'(locked), 1);
        @(negedge clk);
        y_wr = 1'b1; y_data = 6'd5;
        @(negedge clk);
        y_wr = 1'b0;
        chk("R9", "locked cleared after slow Y write", int'(locked), 0);
        period(1'b1, p); chk("R3", "slow fb period Y=5 W=0", p, 96);
        wr(1, 3'd1, 0, 0, 1, 6'd63);
        period(1'b1, p); chk("R3", "slow fb period max", p, 2048);
    endtask

    task automatic test_ext();
        int p;
        int c;
        do_reset(1'b0, 1'b1);
        ref_half = 1;
        fb_pulses(500, c); chk("R7", "ext fb pulses", c, 0);
        chk("R7", "ext locked", int'(locked), 0);
        period(1'b0, p); chk("R2", "ext reset sys period", p, 1);
        wr(1, 3'd5, 1, 1'b1, 1, 6'd4);
        period(1'b0, p); chk("R6", "ext sys period Y=4 X=1", p, 10);
        fb_pulses(500, c); chk("R7", "ext fb pulses after W write", c, 0);
        strap_modck = 1'b1;
        fb_pulses(300, c); chk("R1", "strap change after reset ignored", c, 0);
        chk("R7", "ext locked after writes", int'(locked), 0);
    endtask

    initial begin
        test_fast();
        test_tc();
        test_slow();
        test_ext();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule